// File: doc/BRIEF.md
# Clamped Power-of-Two Clock Divider

This block slows a fast input clock by a power of two. A 4-bit code sets the ratio to 2^code, from 1 up to 512. Codes above nine are clamped to the 512 ratio. Code zero takes the counter out of the path: the input clock is forwarded as the output, and the enable strobe stays asserted.

Inside, a free-running counter spans one output period. From its state the block produces two signals:

- a registered square wave with a 50 % duty cycle;
- a one-cycle enable strobe on the last input cycle of each period.

The code may be changed at any time. The block adopts a new code only when the current output period has finished, so a period in progress always completes at its old length and no shortened high or low phase can appear.

After reset is released, the block spends one input cycle in pass-through. It then samples the code at the next rising edge.

Top module: `pow2_clk_divider`

## Requirements
- R1: For an effective code c from 1 to 9, the enable strobe `tick_o` is high on exactly one input cycle in every 2^c cycles, namely the last cycle of each output period.
- R2: With code 0 adopted, `tick_o` is high on every input cycle, and `div_o` equals `clk_i`: high in the high phase and low in the low phase.
- R3: Codes 10 to 15 give exactly the timing of code 9, that is, a period of 512 input cycles.
- R4: For an effective code c of 1 or more, `div_o` is low for the first 2^(c-1) input cycles of a period and high for the remaining 2^(c-1). The output therefore toggles every 2^(c-1) cycles.
- R5: A code change takes effect only at the end of the current period. The period in progress completes at its old length, and the next period starts low with the new length.
- R6: While `rst_ni` is low, `div_o` and `tick_o` are both low, even in the high phase of `clk_i`.
- R7: In the first input cycle after `rst_ni` rises, the block is in pass-through mode: `tick_o` is high and `div_o` follows `clk_i`. The code present at the next rising edge becomes the first adopted code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 4 | Divide code; the ratio is 2^code, and codes above 9 are clamped to 9 |
| div_o | output | 1 | Divided square wave, or `clk_i` in pass-through mode |
| tick_o | output | 1 | One-cycle enable strobe on the last input cycle of each period |

## Verification
Each result is due in a known cycle:

- **Strobe and square wave.** Both reflect the registers updated at a rising edge. They are valid within that same input cycle, so the bench samples them 1 ns after each edge.
- **Pass-through mode.** The bench also samples `div_o` 1 ns after the falling edge, to confirm that it follows the clock.
- **Code changes.** A new code first matters at the rising edge that ends the current period. The bench therefore drives the code shortly after an edge and keeps a cycle model in which the code is adopted only when the modelled period wraps. Every strobe and output sample is compared against that model, in every cycle of every code from 0 to 15 and across mid-period changes.

// File: rtl/pow2_clk_divider_pkg.sv
package pow2_clk_divider_pkg;

   // Number of bits needed to hold an effective code 0..max_code.
   function automatic int unsigned act_bits(int unsigned max_code);
      return (max_code < 1) ? 1 : $clog2(max_code + 1);
   endfunction

endpackage

// File: rtl/pow2_code_clamp.sv
module pow2_code_clamp #(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned MAX_CODE = 9,
   parameter int unsigned ACT_W    = 4
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [ACT_W-1:0]  eff_o
);

   localparam int unsigned TOP_CODE = (1 << CODE_W) - 1;

   generate
      if (TOP_CODE > MAX_CODE) begin : g_clamp
         always_comb begin
            if (code_i > CODE_W'(MAX_CODE)) eff_o = ACT_W'(MAX_CODE);
            else                            eff_o = ACT_W'(code_i);
         end
      end else begin : g_pass
         always_comb eff_o = ACT_W'(code_i);
      end
   endgenerate

endmodule

// File: rtl/pow2_period_counter.sv
module pow2_period_counter #(
   parameter int unsigned MAX_CODE = 9,
   parameter int unsigned ACT_W    = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ACT_W-1:0]    eff_i,
   output logic [MAX_CODE-1:0] cnt_q,
   output logic [ACT_W-1:0]    act_q,
   output logic                last_o,
   output logic [MAX_CODE-1:0] cnt_n_o,
   output logic [ACT_W-1:0]    act_n_o
);

   localparam int unsigned CNT_W = MAX_CODE;

   logic [CNT_W-1:0] end_mask;

   // Terminal count of the active period: 2^act - 1.
   always_comb begin
      end_mask = CNT_W'((32'd1 << act_q) - 32'd1);
      last_o   = (cnt_q == end_mask);
   end

   always_comb begin
      if (last_o) begin
         cnt_n_o = '0;
         act_n_o = eff_i;
      end else begin
         cnt_n_o = cnt_q + 1'b1;
         act_n_o = act_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         act_q <= '0;
      end else begin
         cnt_q <= cnt_n_o;
         act_q <= act_n_o;
      end
   end

   // R5: the adopted code only moves on the last cycle of a period
   a_r5_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !last_o |=> $stable(act_q));

   // R1: after a period end the count restarts from zero
   a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      last_o |=> (cnt_q == '0));

   // R3: the adopted code never exceeds the clamp limit
   a_r3_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_q <= ACT_W'(MAX_CODE));

endmodule

// File: rtl/pow2_wave_stage.sv
module pow2_wave_stage #(
   parameter int unsigned MAX_CODE = 9,
   parameter int unsigned ACT_W    = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [MAX_CODE-1:0] cnt_n_i,
   input  logic [ACT_W-1:0]    act_n_i,
   output logic                wave_q
);

   localparam int unsigned SEL_N = 1 << ACT_W;

   logic [SEL_N-1:0] half_bit;
   logic             wave_d;

   // half_bit[c] is the bit of the next count that marks the second half of a 2^c period
   assign half_bit[0] = 1'b0;
   generate
      for (genvar i = 1; i < SEL_N; i++) begin : g_sel
         if (i <= MAX_CODE) begin : g_live
            assign half_bit[i] = cnt_n_i[i-1];
         end else begin : g_dead
            assign half_bit[i] = 1'b0;
         end
      end
   endgenerate

   assign wave_d = half_bit[act_n_i];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wave_q <= 1'b0;
      else         wave_q <= wave_d;
   end

endmodule

// File: rtl/pow2_clk_divider.sv
module pow2_clk_divider #(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned MAX_CODE = 9
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] code_i,
   output logic              div_o,
   output logic              tick_o
);

   localparam int unsigned ACT_W = pow2_clk_divider_pkg::act_bits(MAX_CODE);

   initial begin
      assert (MAX_CODE >= 1)
         else $error("MAX_CODE must be at least 1");
      assert (MAX_CODE <= 30)
         else $error("MAX_CODE must not exceed 30");
      assert (MAX_CODE < (1 << CODE_W))
         else $error("CODE_W too narrow to reach MAX_CODE");
   end

   logic [ACT_W-1:0]    eff;
   logic [MAX_CODE-1:0] cnt_q;
   logic [ACT_W-1:0]    act_q;
   logic                last;
   logic [MAX_CODE-1:0] cnt_n;
   logic [ACT_W-1:0]    act_n;
   logic                wave_q;
   logic                bypass;

   pow2_code_clamp #(
      .CODE_W   (CODE_W),
      .MAX_CODE (MAX_CODE),
      .ACT_W    (ACT_W)
   ) i_clamp (
      .code_i (code_i),
      .eff_o  (eff)
   );

   pow2_period_counter #(
      .MAX_CODE (MAX_CODE),
      .ACT_W    (ACT_W)
   ) i_count (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .eff_i   (eff),
      .cnt_q   (cnt_q),
      .act_q   (act_q),
      .last_o  (last),
      .cnt_n_o (cnt_n),
      .act_n_o (act_n)
   );

   pow2_wave_stage #(
      .MAX_CODE (MAX_CODE),
      .ACT_W    (ACT_W)
   ) i_wave (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_n_i (cnt_n),
      .act_n_i (act_n),
      .wave_q  (wave_q)
   );

   assign bypass = rst_ni && (act_q == '0);
   assign div_o  = bypass ? clk_i : wave_q;
   assign tick_o = rst_ni && last;

   // R4: every divided period starts in its low half
   a_r4_starts_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((act_q != '0) && (cnt_q == '0)) |-> !wave_q);

   // R4: the strobe cycle lies in the high half of a divided period
   a_r4_ends_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((act_q != '0) && tick_o) |-> wave_q);

endmodule

// File: tb/test_pow2_clk_divider.sv
`timescale 1ns/1ps
module test_pow2_clk_divider;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [3:0] code_i = 4'd0;
   logic       div_o;
   logic       tick_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   int m_act = 0;
   int m_cnt = 0;

   always #2.5 clk_i = ~clk_i;

   pow2_clk_divider i_pow2_clk_divider (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .code_i (code_i),
      .div_o  (div_o),
      .tick_o (tick_o)
   );

   function automatic int clampc(int c);
      return (c > 9) ? 9 : c;
   endfunction

   task automatic chk(string tag, logic got, logic exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b (code %0d, t=%0t)", tag, got, exp, code_i, $time);
      end
   endtask

   // One input cycle: model update at the edge, then samples at +1 ns (clk high)
   // and at +3.5 ns (clk low, pass-through only).
   task automatic step(string tag);
      @(posedge clk_i);
      if (m_cnt == (1 << m_act) - 1) begin
         m_cnt = 0;
         m_act = clampc(int'(code_i));
      end else begin
         m_cnt++;
      end
      #1;
      chk(tag, tick_o, (m_cnt == (1 << m_act) - 1));
      if (m_act == 0) chk("R2", div_o, 1'b1);
      else            chk("R4", div_o, (m_cnt >= (1 << (m_act - 1))));
      #2.5;
      if (m_act == 0) chk("R2", div_o, 1'b0);
   endtask

   task automatic run(string tag, int n);
      for (int k = 0; k < n; k++) step(tag);
   endtask

   initial begin
      // R6: outputs low throughout reset, sampled with clk high and low
      for (int k = 0; k < 3; k++) begin
         @(posedge clk_i); #1;
         chk("R6", div_o, 1'b0);
         chk("R6", tick_o, 1'b0);
         #2.5;
         chk("R6", div_o, 1'b0);
      end
      code_i = 4'd3;
      @(posedge clk_i); #1;
      rst_ni = 1'b1;
      m_act = 0;
      m_cnt = 0;
      #0.5;
      // R7: first cycle after release is pass-through
      chk("R7", tick_o, 1'b1);
      chk("R7", div_o, 1'b1);
      #2.5;
      chk("R7", div_o, 1'b0);
      // R7: code present at the next edge is adopted
      run("R7", 24);

      // R1: every ratio from 2 to 512
      for (int c = 1; c <= 9; c++) begin
         code_i = 4'(c);
         run("R1", 512 + 2 * (1 << c));
      end

      // R2: pass-through
      code_i = 4'd0;
      run("R2", 600);

      // R3: codes 10..15 behave as 9
      for (int c = 10; c <= 15; c++) begin
         code_i = 4'(c);
         run("R3", 512 + 1024);
      end

      // R5: changes in the middle of a period
      code_i = 4'd9;
      run("R5", 600);
      code_i = 4'd2;
      run("R5", 530);
      code_i = 4'd5;
      run("R5", 1);
      code_i = 4'd1;
      run("R5", 40);
      code_i = 4'd0;
      run("R5", 10);
      code_i = 4'd6;
      run("R5", 3);
      code_i = 4'd12;
      run("R5", 1100);
      code_i = 4'd4;
      run("R5", 530);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule